// File: doc/BRIEF.md
# Three-Unit Conversion Window Watchdog

This block watches the stream of conversion results coming out of a converter and tells the rest of the chip when a result leaves a programmed window. Every result arrives with its channel number, a resolution code and a one-cycle valid strobe. The block first moves the raw value to the top of a 12-bit field. Three independent watchdog units then compare it against their own low and high limits.

Unit 1 compares all 12 bits and guards either one chosen channel or every channel. Units 2 and 3 each guard an arbitrary set of channels picked by a 19-bit mask, and they compare only the upper 8 bits of the value. Each unit has three outputs:

- a sticky flag, cleared by a write-1 clear strobe;
- an interrupt request, gated by an enable;
- a live window output, for a timer, that follows the most recent guarded result whatever the flag holds.

All configuration arrives on plain ports. Alignment, offset correction and any register bus sit outside the block.

Top module: `awd_top`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, all bits of `flag`, `irq` and `win_out` are 0.
- R2: The resolution code `res_mode` selects the significant width of `res_data`: 0 means 12 bits, 1 means 10, 2 means 8 and 3 means 6. The low bits `res_data[w-1:0]` are shifted left by 12-w before comparison. Bits at or above w are ignored.
- R3: A result is outside a window when the compared value is strictly greater than the high limit or strictly less than the low limit. A value equal to either limit is inside.
- R4: Unit 1 (bit 0 of every output vector) guards a result only when `w1_en` is 1 and either `w1_all` is 1 or `res_chan` equals `w1_chan`. It compares the full 12-bit justified value against `w1_lo`/`w1_hi`.
- R5: Unit 2 (bit 1) guards a result when `w2_mask[res_chan]` is 1, and unit 3 (bit 2) when `w3_mask[res_chan]` is 1. A result with `res_chan` of 19 or more is guarded by no unit, including unit 1 in all-channel mode.
- R6: Units 2 and 3 compare bits [11:4] of the justified value against their 8-bit limits.
- R7: On the clock edge that samples a guarded result, `win_out` of that unit takes 1 if the result is outside and 0 if it is inside. Otherwise `win_out` holds its value.
- R8: A unit's `flag` bit becomes 1 on the edge that samples a guarded outside result. It stays 1 through later inside results until it is cleared.
- R9: A 1 on `flag_clr[i]` clears `flag[i]` at that edge. If a guarded outside result for the same unit is sampled at the same edge, the flag is set instead.
- R10: After each edge, `irq[i]` equals the new `flag[i]` ANDed with the value `irq_en[i]` had before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | One-cycle strobe marking a new result |
| res_data | input | 12 | Raw result, right-justified |
| res_chan | input | 5 | Channel number of the result |
| res_mode | input | 2 | Resolution code (0:12, 1:10, 2:8, 3:6 bits) |
| w1_en | input | 1 | Unit 1 enable |
| w1_all | input | 1 | Unit 1 guards all channels |
| w1_chan | input | 5 | Unit 1 single guarded channel |
| w1_lo | input | 12 | Unit 1 low limit |
| w1_hi | input | 12 | Unit 1 high limit |
| w2_mask | input | 19 | Unit 2 channel mask |
| w2_lo | input | 8 | Unit 2 low limit |
| w2_hi | input | 8 | Unit 2 high limit |
| w3_mask | input | 19 | Unit 3 channel mask |
| w3_lo | input | 8 | Unit 3 low limit |
| w3_hi | input | 8 | Unit 3 high limit |
| irq_en | input | 3 | Interrupt enable per unit |
| flag_clr | input | 3 | Write-1 clear per unit flag |
| flag | output | 3 | Sticky out-of-window flags |
| irq | output | 3 | Interrupt requests |
| win_out | output | 3 | Live out-of-window outputs |

## Verification
A clear strobe and a guarded outside result can reach the same unit in the same cycle. The flag must then end up set, not cleared. The sweep raises `flag_clr` on every other result while it walks all 4096 codes through every resolution and channel 0 to 23. A reference model applies clear first and set second, and each unit's flag, interrupt and live output are compared with it one cycle later. Directed steps then pulse the clear with no result, so the two cases can be told apart.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int FULL_W   = 12;
  localparam int NARROW_W = 8;
  localparam int NUM_CHAN = 19;
  localparam int CHAN_W   = $clog2(NUM_CHAN);
  localparam int MODE_W   = 2;
  localparam int NUM_UNIT = 3;

  typedef enum logic [MODE_W-1:0] {
    RES_FULL  = 2'd0,
    RES_TEN   = 2'd1,
    RES_EIGHT = 2'd2,
    RES_SIX   = 2'd3
  } res_mode_e;
endpackage

// File: rtl/awd_norm.sv
module awd_norm
  import awd_pkg::*;
#(
  parameter int W = FULL_W
) (
  input  logic [W-1:0]      raw,
  input  logic [MODE_W-1:0] mode,
  output logic [W-1:0]      just
);
  localparam int STEP = 2;

  // Each resolution code drops STEP more bits; unused upper bits are masked off.
  logic [W-1:0] cand [2**MODE_W];

  for (genvar m = 0; m < 2**MODE_W; m++) begin : g_mode
    localparam int SH = m * STEP;
    if (SH == 0) begin : g_full
      assign cand[m] = raw;
    end else begin : g_shift
      assign cand[m] = {raw[W-SH-1:0], {SH{1'b0}}};
    end
  end

  always_comb begin
    just = cand[mode];
  end
endmodule

// File: rtl/awd_chan_sel.sv
module awd_chan_sel
  import awd_pkg::*;
#(
  parameter int NCH = NUM_CHAN,
  parameter int CW  = CHAN_W
) (
  input  logic [CW-1:0]  chan,
  input  logic [NCH-1:0] mask,
  input  logic [CW-1:0]  single,
  output logic           exists,
  output logic           mask_hit,
  output logic           single_hit
);
  logic [NCH-1:0] dec;

  // One-hot decode; channels at or above NCH decode to all zero.
  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign dec[c] = (chan == CW'(c));
  end

  always_comb begin
    exists     = |dec;
    mask_hit   = |(dec & mask);
    single_hit = exists && (chan == single);
  end
endmodule

// File: rtl/awd_unit.sv
module awd_unit #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         guard,
  input  logic [W-1:0] value,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic         clr,
  input  logic         ie,
  output logic         flag_q,
  output logic         irq_q,
  output logic         live_q
);
  logic outside;
  logic hit;
  logic flag_n;

  always_comb begin
    outside = (value > hi) || (value < lo);
    hit     = guard && outside;
    // A new event wins over a clear in the same cycle.
    flag_n  = hit || (flag_q && !clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      flag_q <= flag_n;
      irq_q  <= flag_n && ie;
      if (guard) begin
        live_q <= outside;
      end
    end
  end
endmodule

// File: rtl/awd_top.sv
module awd_top
  import awd_pkg::*;
#(
  parameter int DW  = FULL_W,
  parameter int NW  = NARROW_W,
  parameter int NCH = NUM_CHAN,
  parameter int CW  = CHAN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [DW-1:0]     res_data,
  input  logic [CW-1:0]     res_chan,
  input  logic [MODE_W-1:0] res_mode,
  input  logic              w1_en,
  input  logic              w1_all,
  input  logic [CW-1:0]     w1_chan,
  input  logic [DW-1:0]     w1_lo,
  input  logic [DW-1:0]     w1_hi,
  input  logic [NCH-1:0]    w2_mask,
  input  logic [NW-1:0]     w2_lo,
  input  logic [NW-1:0]     w2_hi,
  input  logic [NCH-1:0]    w3_mask,
  input  logic [NW-1:0]     w3_lo,
  input  logic [NW-1:0]     w3_hi,
  input  logic [2:0]        irq_en,
  input  logic [2:0]        flag_clr,
  output logic [2:0]        flag,
  output logic [2:0]        irq,
  output logic [2:0]        win_out
);
  localparam int NU = NUM_UNIT;

  logic [DW-1:0]  just;
  logic [NW-1:0]  narrow;
  logic [NU-1:0]  guard;
  logic [NCH-1:0] masks [1:NU-1];
  logic [NW-1:0]  los   [1:NU-1];
  logic [NW-1:0]  his   [1:NU-1];
  logic [NU-1:0]  mhit;
  logic [NU-1:0]  exists;
  logic [NU-1:0]  shit;

  assign masks[1] = w2_mask;
  assign masks[2] = w3_mask;
  assign los[1]   = w2_lo;
  assign los[2]   = w3_lo;
  assign his[1]   = w2_hi;
  assign his[2]   = w3_hi;

  awd_norm #(.W(DW)) u_norm (
    .raw  (res_data),
    .mode (res_mode),
    .just (just)
  );

  assign narrow = just[DW-1 -: NW];

  for (genvar u = 0; u < NU; u++) begin : g_unit
    if (u == 0) begin : g_full
      awd_chan_sel #(.NCH(NCH), .CW(CW)) u_sel (
        .chan       (res_chan),
        .mask       ({NCH{1'b1}}),
        .single     (w1_chan),
        .exists     (exists[u]),
        .mask_hit   (mhit[u]),
        .single_hit (shit[u])
      );
      assign guard[u] = res_valid && w1_en && (w1_all ? mhit[u] : shit[u]);
      awd_unit #(.W(DW)) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .guard  (guard[u]),
        .value  (just),
        .lo     (w1_lo),
        .hi     (w1_hi),
        .clr    (flag_clr[u]),
        .ie     (irq_en[u]),
        .flag_q (flag[u]),
        .irq_q  (irq[u]),
        .live_q (win_out[u])
      );
    end else begin : g_narrow
      awd_chan_sel #(.NCH(NCH), .CW(CW)) u_sel (
        .chan       (res_chan),
        .mask       (masks[u]),
        .single     ({CW{1'b0}}),
        .exists     (exists[u]),
        .mask_hit   (mhit[u]),
        .single_hit (shit[u])
      );
      assign guard[u] = res_valid && mhit[u];
      awd_unit #(.W(NW)) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .guard  (guard[u]),
        .value  (narrow),
        .lo     (los[u]),
        .hi     (his[u]),
        .clr    (flag_clr[u]),
        .ie     (irq_en[u]),
        .flag_q (flag[u]),
        .irq_q  (irq[u]),
        .live_q (win_out[u])
      );
    end
  end
endmodule

// File: rtl/awd_chk.sv
module awd_chk (
  input logic       clk,
  input logic       rst,
  input logic       res_valid,
  input logic [2:0] irq_en,
  input logic [2:0] flag_clr,
  input logic [2:0] flag,
  input logic [2:0] irq,
  input logic [2:0] win_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flag == 3'b0 && irq == 3'b0 && win_out == 3'b0));

  // R7
  live_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> $stable(win_out));

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == (flag & $past(irq_en))));

  for (genvar i = 0; i < 3; i++) begin : g_u
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (flag[i] && !flag_clr[i]) |=> flag[i]);

    // R8
    flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(flag[i]) |-> $past(res_valid));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (flag_clr[i] && !res_valid) |=> !flag[i]);
  end
endmodule

bind awd_top awd_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .res_valid (res_valid),
  .irq_en    (irq_en),
  .flag_clr  (flag_clr),
  .flag      (flag),
  .irq       (irq),
  .win_out   (win_out)
);

// File: tb/sim_awd_top.sv
module sim_awd_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        res_valid = 1'b0;
  logic [11:0] res_data = '0;
  logic [4:0]  res_chan = '0;
  logic [1:0]  res_mode = '0;
  logic        w1_en = 1'b0;
  logic        w1_all = 1'b0;
  logic [4:0]  w1_chan = '0;
  logic [11:0] w1_lo = '0;
  logic [11:0] w1_hi = '0;
  logic [18:0] w2_mask = '0;
  logic [7:0]  w2_lo = '0;
  logic [7:0]  w2_hi = '0;
  logic [18:0] w3_mask = '0;
  logic [7:0]  w3_lo = '0;
  logic [7:0]  w3_hi = '0;
  logic [2:0]  irq_en = '0;
  logic [2:0]  flag_clr = '0;
  logic [2:0]  flag;
  logic [2:0]  irq;
  logic [2:0]  win_out;

  int checks = 0;
  int errors = 0;
  logic [2:0] m_flag = '0;
  logic [2:0] m_irq = '0;
  logic [2:0] m_win = '0;

  always #5 clk = ~clk;

  awd_top u0 (.*);

  task automatic check3(input logic [2:0] act, input logic [2:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // R2: the significant width is 12 - 2*mode; keep the low bits and move them to the top.
  function automatic int justify(input int d, input int md);
    int b;
    b = 12 - 2 * md;
    return (d % (1 << b)) * (1 << (12 - b));
  endfunction

  // One result (or idle cycle) per call; called and returning at a falling edge.
  task automatic step(input int d, input int ch, input int md, input logic v, input logic [2:0] clr);
    int n;
    logic [2:0] g;
    logic [2:0] o;
    n = justify(d, md);
    g[0] = v && (ch < 19) && w1_en && (w1_all || ch == int'(w1_chan));
    g[1] = v && (ch < 19) && ((ch < 19) ? w2_mask[ch % 19] : 1'b0);
    g[2] = v && (ch < 19) && ((ch < 19) ? w3_mask[ch % 19] : 1'b0);
    o[0] = (n > int'(w1_hi)) || (n < int'(w1_lo));
    o[1] = ((n >> 4) > int'(w2_hi)) || ((n >> 4) < int'(w2_lo));
    o[2] = ((n >> 4) > int'(w3_hi)) || ((n >> 4) < int'(w3_lo));
    res_data  = 12'(d);
    res_chan  = 5'(ch);
    res_mode  = 2'(md);
    res_valid = v;
    flag_clr  = clr;
    m_flag = (m_flag & ~clr) | (g & o);
    for (int i = 0; i < 3; i++) if (g[i]) m_win[i] = o[i];
    m_irq = m_flag & irq_en;
    @(negedge clk);
    res_valid = 1'b0;
    flag_clr  = '0;
    check3(win_out, m_win, "R2 R3 R4 R5 R6 R7");
    check3(flag, m_flag, "R8 R9");
    check3(irq, m_irq, "R10");
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check3(flag, 3'b0, "R1");
    check3(irq, 3'b0, "R1");
    check3(win_out, 3'b0, "R1");
    rst = 1'b0;
    @(negedge clk);
    check3(flag | irq | win_out, 3'b0, "R1");

    w1_lo = 12'h400; w1_hi = 12'hB00;
    w2_mask = 19'h7FFFF; w2_lo = 8'h40; w2_hi = 8'hB0;
    w3_mask = 19'h00F0F; w3_lo = 8'h80; w3_hi = 8'hFF;
    irq_en = 3'b111;

    // Sweep: unit 1 all-channel, then single channel 5, then disabled (R4, R5).
    for (int cfg = 0; cfg < 3; cfg++) begin
      w1_en   = (cfg != 2);
      w1_all  = (cfg == 0);
      w1_chan = 5'd5;
      for (int md = 0; md < 4; md++) begin
        for (int v = 0; v < 4096; v++) begin
          step(v, v % 24, md, 1'b1, (v % 2 == 1) ? 3'b111 : 3'b000);
        end
      end
    end

    // Directed cases.
    w1_en = 1'b1; w1_all = 1'b1;
    step(0, 0, 0, 1'b1, 3'b000);      // R8: outside on all three units sets every flag
    step(0, 0, 0, 1'b0, 3'b000);      // R7: idle cycle holds the live outputs
    step(12'h800, 1, 0, 1'b1, 3'b000); // R8: inside result leaves the flags set
    step(12'h800, 20, 0, 1'b1, 3'b000); // R5: channel 20 is not guarded by any unit
    irq_en = 3'b010;
    step(0, 0, 0, 1'b0, 3'b000);      // R10: interrupt follows its enable
    step(0, 0, 0, 1'b0, 3'b111);      // R9: clear with no result
    step(12'h3FF, 2, 0, 1'b1, 3'b001); // R9: same-cycle set on unit 1 beats its clear
    step(12'h400, 2, 0, 1'b1, 3'b000); // R3: equal to the low limit is inside
    step(12'hB00, 2, 0, 1'b1, 3'b000); // R3: equal to the high limit is inside
    step(12'hB01, 2, 0, 1'b1, 3'b000); // R3: one above the high limit is outside
    step(12'hFFF, 3, 3, 1'b1, 3'b000); // R2: 6-bit code 0x3F justifies to 0xFC0

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule